// File: doc/BRIEF.md
# Configurable-Priority Interrupt Controller

This block gathers interrupt events from a set of peripheral sources. It holds each one in a sticky pending bit until software clears it with a write-one-to-clear strobe. On every clock it picks the single most urgent source that is both pending and enabled, and presents a 6-bit vector naming it. Alongside the ordinary interrupt request it keeps a separate machine-check path. Events such as watchdog expiry, an external non-maskable line, memory ECC errors, host-bridge faults and bus timeouts feed that path. It stays apart from the vectored interrupt logic.

Priority is mostly fixed, with lower source index winning. Three equal-size peripheral groups sit in the middle of the order, and a 2-bit field can rearrange them at run time. One source chosen by software can also be lifted above everything else. One source is an aggregate of several event bits, and each of those bits has its own enable. A core-enable input decides where the requests go. They drive the on-chip core when it is enabled. Otherwise they drive two output pins, so an external processor can service them.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While rst_n is low, all pending state clears and vec, core_int, core_mcp, int_pin and nmi_pin are 0.
- R2: A high src_evt bit at a clock edge sets the matching pending bit, which stays set until a src_clr strobe for that bit. If set and clear arrive in the same cycle, the bit stays set.
- R3: A request is raised one cycle after some source is both pending and enabled in src_mask. A source that is disabled by its mask is hidden but keeps its pending bit, so it returns when its mask bit is set again.
- R4: vec equals the winning source index plus 1, or 0 when nothing is pending and enabled. vec reflects the pending, mask and priority settings one cycle later.
- R5: Sources 0 to 3 outrank the groups and sources 28 to 31 rank below them, with lower index first inside each range. Group A is sources 4 to 11, B is 12 to 19 and C is 20 to 27. grp_order selects the group order: 0 gives A,B,C; 1 gives B,A,C; 2 gives C,A,B; 3 gives A,C,B.
- R6: When ovr_en is 1 and the source numbered ovr_src (an index below 32) is pending and enabled, that source wins over all others. A non-eligible ovr_src has no effect.
- R7: Source 2 also becomes pending when any bit of sub_evt is high together with the same bit of sub_mask. A sub-event whose sub_mask bit is 0 leaves it untouched.
- R8: Each of the 5 mc_evt bits sets a sticky machine-check pending bit that is cleared by the matching mc_clr bit. The machine-check request is high in the cycle after any of these bits is set.
- R9: With core_en 1, the requests drive core_int and core_mcp and both pins stay 0. With core_en 0, they drive int_pin and nmi_pin instead and the core outputs stay 0. The routing follows core_en combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 32 | Per-source event strobes |
| src_mask | input | 32 | Per-source enable, 1 = enabled |
| src_clr | input | 32 | Write-one-to-clear strobes for pending bits |
| sub_evt | input | 4 | Event bits of the aggregated sub-block (source 2) |
| sub_mask | input | 4 | Enables for sub_evt bits |
| grp_order | input | 2 | Group order selection |
| ovr_en | input | 1 | Enables the top-priority override |
| ovr_src | input | 6 | Source index lifted to top priority |
| mc_evt | input | 5 | Machine-check event strobes |
| mc_clr | input | 5 | Clear strobes for machine-check pending bits |
| core_en | input | 1 | 1 = internal core serves requests |
| core_int | output | 1 | Interrupt request to internal core |
| core_mcp | output | 1 | Machine-check request to internal core |
| int_pin | output | 1 | Interrupt request pin for an external processor |
| nmi_pin | output | 1 | Machine-check pin for an external processor |
| vec | output | 6 | Winning source index plus 1, 0 when idle |

## Verification
The bench goes after three kinds of corner case: set and clear hitting one pending bit in the same cycle, masking a pending source and unmasking it later, and every grp_order value with one source pending in each group. An implementation that let clear win would drop a real event. One that cleared on mask would lose the interrupt for good. A mistake in the group permutation table would report the wrong group's vector. The override is tried on pending and non-pending targets, because a design that ignores eligibility there would report a vector for an idle source. Flipping core_en with requests outstanding catches any path that drives both the core outputs and the pins, or neither.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC    = 32,
  parameter int GBASE   = 4,
  parameter int GSZ     = 8,
  parameter int SUB_SRC = 2,
  parameter int SUBW    = 4,
  parameter int NMC     = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_evt,
  input  logic [NSRC-1:0] src_mask,
  input  logic [NSRC-1:0] src_clr,
  input  logic [SUBW-1:0] sub_evt,
  input  logic [SUBW-1:0] sub_mask,
  input  logic [1:0]      grp_order,
  input  logic            ovr_en,
  input  logic [5:0]      ovr_src,
  input  logic [NMC-1:0]  mc_evt,
  input  logic [NMC-1:0]  mc_clr,
  input  logic            core_en,
  output logic            core_int,
  output logic            core_mcp,
  output logic            int_pin,
  output logic            nmi_pin,
  output logic [5:0]      vec
);
  localparam int GEND = GBASE + 3 * GSZ;

  logic [NSRC-1:0] pend, elig, set_v;
  logic [NMC-1:0]  mc_pend;
  logic [63:0]     elig_w;
  logic [5:0]      win, vec_q;
  logic            win_vld, req_q, mc_any;

  assign set_v  = src_evt | (NSRC'(|(sub_evt & sub_mask)) << SUB_SRC);
  assign elig   = pend & src_mask;
  assign elig_w = 64'(elig);

  function automatic int slot_grp(input logic [1:0] o, input int s);
    case (o)
      2'd0:    return s;
      2'd1:    return (s == 0) ? 1 : (s == 1) ? 0 : 2;
      2'd2:    return (s == 0) ? 2 : s - 1;
      default: return (s == 0) ? 0 : (s == 1) ? 2 : 1;
    endcase
  endfunction

  function automatic int pos_src(input logic [1:0] o, input int p);
    if (p >= GBASE && p < GEND)
      return GBASE + slot_grp(o, (p - GBASE) / GSZ) * GSZ + (p - GBASE) % GSZ;
    return p;
  endfunction

  always_comb begin
    win_vld = 1'b0;
    win     = '0;
    for (int p = NSRC - 1; p >= 0; p--) begin
      if (elig_w[6'(pos_src(grp_order, p))]) begin
        win_vld = 1'b1;
        win     = 6'(pos_src(grp_order, p));
      end
    end
    if (ovr_en && int'(ovr_src) < NSRC && elig_w[ovr_src]) begin
      win_vld = 1'b1;
      win     = ovr_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      mc_pend <= '0;
      vec_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      pend    <= (pend & ~src_clr) | set_v;
      mc_pend <= (mc_pend & ~mc_clr) | mc_evt;
      req_q   <= win_vld;
      vec_q   <= win_vld ? win + 6'd1 : 6'd0;
    end
  end

  assign mc_any   = |mc_pend;
  assign vec      = vec_q;
  assign core_int = req_q & core_en;
  assign int_pin  = req_q & ~core_en;
  assign core_mcp = mc_any & core_en;
  assign nmi_pin  = mc_any & ~core_en;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NSRC = 32,
  parameter int NMC  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] src_mask,
  input logic [NSRC-1:0] src_clr,
  input logic            ovr_en,
  input logic [5:0]      ovr_src,
  input logic [NMC-1:0]  mc_evt,
  input logic            core_en,
  input logic            core_int,
  input logic            core_mcp,
  input logic            int_pin,
  input logic            nmi_pin,
  input logic [5:0]      vec
);
  logic [63:0] elig_w;
  assign elig_w = 64'(pend & src_mask);

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(pend & ~src_clr)) == $past(pend & ~src_clr)));

  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_w == 64'd0) |=> (vec == 6'd0 && !core_int && !int_pin));

  a_r4_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(vec) <= NSRC);

  a_r6_override: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && int'(ovr_src) < NSRC && |(elig_w & (64'd1 << ovr_src)))
      |=> (vec == $past(ovr_src) + 6'd1));

  a_r8_mc_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (|mc_evt) |=> (core_mcp || nmi_pin));

  a_r9_core_route: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> (!int_pin && !nmi_pin));

  a_r9_pin_route: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |-> (!core_int && !core_mcp));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NSRC(NSRC), .NMC(NMC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend), .src_mask(src_mask),
  .src_clr(src_clr), .ovr_en(ovr_en), .ovr_src(ovr_src), .mc_evt(mc_evt),
  .core_en(core_en), .core_int(core_int), .core_mcp(core_mcp),
  .int_pin(int_pin), .nmi_pin(nmi_pin), .vec(vec)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  localparam int NSRC = 32, GBASE = 4, GSZ = 8, SUB_SRC = 2, SUBW = 4, NMC = 5;
  localparam int GEND = GBASE + 3 * GSZ;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] src_evt = '0, src_mask = '1, src_clr = '0;
  logic [SUBW-1:0] sub_evt = '0, sub_mask = '0;
  logic [1:0] grp_order = 2'd0;
  logic ovr_en = 1'b0;
  logic [5:0] ovr_src = '0;
  logic [NMC-1:0] mc_evt = '0, mc_clr = '0;
  logic core_en = 1'b1;
  logic core_int, core_mcp, int_pin, nmi_pin;
  logic [5:0] vec;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .src_mask(src_mask),
    .src_clr(src_clr), .sub_evt(sub_evt), .sub_mask(sub_mask),
    .grp_order(grp_order), .ovr_en(ovr_en), .ovr_src(ovr_src),
    .mc_evt(mc_evt), .mc_clr(mc_clr), .core_en(core_en),
    .core_int(core_int), .core_mcp(core_mcp), .int_pin(int_pin),
    .nmi_pin(nmi_pin), .vec(vec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic [NSRC-1:0] m_pend = '0;
  logic [NMC-1:0]  m_mc = '0;
  int e_vec = 0;
  bit e_req = 0;
  int order_q[$];
  int seq[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = '0; m_mc = '0; e_vec = 0; e_req = 0;
    end else begin
      int hit;
      order_q = {};
      case (grp_order)
        2'd0: seq = '{0, 1, 2};
        2'd1: seq = '{1, 0, 2};
        2'd2: seq = '{2, 0, 1};
        default: seq = '{0, 2, 1};
      endcase
      if (ovr_en && int'(ovr_src) < NSRC) order_q.push_back(int'(ovr_src));
      for (int i = 0; i < GBASE; i++) order_q.push_back(i);
      for (int k = 0; k < 3; k++)
        for (int j = 0; j < GSZ; j++) order_q.push_back(GBASE + seq[k] * GSZ + j);
      for (int i = GEND; i < NSRC; i++) order_q.push_back(i);
      hit = -1;
      foreach (order_q[k])
        if (hit < 0 && m_pend[order_q[k]] && src_mask[order_q[k]]) hit = order_q[k];
      e_req = (hit >= 0);
      e_vec = hit + 1;
      m_pend = (m_pend & ~src_clr) | src_evt;
      if (|(sub_evt & sub_mask)) m_pend[SUB_SRC] = 1'b1;
      m_mc = (m_mc & ~mc_clr) | mc_evt;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 R5 R6 vec", int'(vec), e_vec);
      chk("R3 R9 core_int", int'(core_int), int'(e_req && core_en));
      chk("R3 R9 int_pin", int'(int_pin), int'(e_req && !core_en));
      chk("R8 R9 core_mcp", int'(core_mcp), int'((|m_mc) && core_en));
      chk("R8 R9 nmi_pin", int'(nmi_pin), int'((|m_mc) && !core_en));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic [NSRC-1:0] b);
    src_evt = b; cyc(1); src_evt = '0; cyc(1);
  endtask

  task automatic clr(input logic [NSRC-1:0] b);
    src_clr = b; cyc(1); src_clr = '0; cyc(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    chk("R1 vec in reset", int'(vec), 0);
    chk("R1 core_int in reset", int'(core_int), 0);
    chk("R1 core_mcp in reset", int'(core_mcp), 0);
    #1 rst_n = 1'b1;
    cyc(1);
    chk("R1 vec after reset", int'(vec), 0);

    pulse(NSRC'(1) << 9);
    chk("R4 single source 9", int'(vec), 10);
    chk("R3 request raised", int'(core_int), 1);
    pulse(NSRC'(1) << 30);
    chk("R5 group A over tail", int'(vec), 10);
    clr(NSRC'(1) << 9);
    chk("R2 clear reveals 30", int'(vec), 31);
    src_evt = NSRC'(1) << 30; src_clr = NSRC'(1) << 30; cyc(1);
    src_evt = '0; src_clr = '0; cyc(1);
    chk("R2 set beats clear", int'(vec), 31);
    clr('1);
    chk("R4 idle vector", int'(vec), 0);
    chk("R4 idle request", int'(core_int), 0);

    pulse((NSRC'(1) << 5) | (NSRC'(1) << 13) | (NSRC'(1) << 21));
    chk("R5 order0", int'(vec), 6);
    grp_order = 2'd1; cyc(1);
    chk("R5 order1", int'(vec), 14);
    grp_order = 2'd2; cyc(1);
    chk("R5 order2", int'(vec), 22);
    grp_order = 2'd3; cyc(1);
    chk("R5 order3", int'(vec), 6);
    clr(NSRC'(1) << 5);
    chk("R5 order3 C before B", int'(vec), 22);
    grp_order = 2'd1; cyc(1);
    chk("R5 order1 B first", int'(vec), 14);
    pulse(NSRC'(1) << 1);
    chk("R5 head over groups", int'(vec), 2);
    grp_order = 2'd0;
    clr('1);

    pulse((NSRC'(1) << 1) | (NSRC'(1) << 30));
    chk("R6 no override", int'(vec), 2);
    ovr_en = 1'b1; ovr_src = 6'd30; cyc(1);
    chk("R6 override to 30", int'(vec), 31);
    ovr_src = 6'd25; cyc(1);
    chk("R6 idle override target", int'(vec), 2);
    ovr_src = 6'd30;
    src_mask = ~((NSRC'(1) << 1) | (NSRC'(1) << 30)); cyc(1);
    chk("R3 masked vector", int'(vec), 0);
    chk("R3 masked request", int'(core_int), 0);
    src_mask = '1; cyc(1);
    chk("R3 unmask restores", int'(vec), 31);
    chk("R3 unmask request", int'(core_int), 1);
    ovr_en = 1'b0;
    clr('1);

    sub_evt = 4'b0100; cyc(1); sub_evt = '0; cyc(1);
    chk("R7 masked sub event", int'(vec), 0);
    sub_mask = 4'b0100; sub_evt = 4'b0100; cyc(1); sub_evt = '0; cyc(1);
    chk("R7 enabled sub event", int'(vec), 3);
    sub_mask = '0;
    clr('1);

    mc_evt = 5'b00100; cyc(1); mc_evt = '0;
    chk("R8 machine check raised", int'(core_mcp), 1);
    cyc(1);
    chk("R8 machine check sticky", int'(core_mcp), 1);
    chk("R8 no vectored request", int'(core_int), 0);
    mc_clr = 5'b00100; cyc(1); mc_clr = '0;
    chk("R8 machine check cleared", int'(core_mcp), 0);

    pulse(NSRC'(1) << 7);
    core_en = 1'b0; #1;
    chk("R9 int on pin", int'(int_pin), 1);
    chk("R9 core int off", int'(core_int), 0);
    mc_evt = 5'b00001; cyc(1); mc_evt = '0;
    chk("R9 nmi on pin", int'(nmi_pin), 1);
    chk("R9 core mcp off", int'(core_mcp), 0);
    core_en = 1'b1; #1;
    chk("R9 int back to core", int'(core_int), 1);
    chk("R9 pin released", int'(int_pin), 0);
    mc_clr = '1; src_clr = '1; cyc(1); mc_clr = '0; src_clr = '0; cyc(1);

    for (int n = 0; n < 600; n++) begin
      src_evt = ($urandom % 3 == 0) ? (NSRC'(1) << ($urandom % NSRC)) : '0;
      src_clr = ($urandom % 4 == 0) ? (NSRC'(1) << ($urandom % NSRC)) : '0;
      if ($urandom % 8 == 0) src_mask = NSRC'($urandom) | NSRC'($urandom);
      if ($urandom % 10 == 0) grp_order = 2'($urandom);
      if ($urandom % 10 == 0) begin ovr_en = 1'($urandom); ovr_src = 6'($urandom % 40); end
      sub_evt = SUBW'($urandom); sub_mask = SUBW'($urandom) & SUBW'($urandom);
      mc_evt = ($urandom % 12 == 0) ? NMC'(1) << ($urandom % NMC) : '0;
      mc_clr = ($urandom % 6 == 0) ? NMC'($urandom) : '0;
      if ($urandom % 16 == 0) core_en = ~core_en;
      cyc(1);
    end
    src_evt = '0; src_clr = '0; mc_evt = '0; mc_clr = '0; sub_evt = '0;
    cyc(2);
    @(negedge clk);
    finish_run();
  end
endmodule